// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a small set of external interrupt lines and turns pin activity into interrupt requests. Each channel has its own 2-bit sense mode. The mode selects one of four triggers: a low level, any change, a falling edge or a rising edge. Each pad passes through a synchroniser, and an edge register then compares the current sample with the previous one. Edge and change events set a sticky pending flag, which stays set until the CPU acknowledges it or software clears it by writing one. In low-level mode nothing is latched: the pending output follows the synchronised pin and is set only while the pin is low.

Each channel can also take its pad value from the chip's own output driver. When the pin direction is output, the block senses the value being driven. Software can therefore raise an interrupt by writing the pin. Each channel has a mask bit, and a global enable gates all channels. The enabled pending flags combine into one request line, together with the index of the channel to serve, and the lowest-numbered channel wins.

Top module: `ext_irq_sense`

## Requirements
- R1: Out of reset, with pads idle high and every sense field at 00, `pend_o`, `irq_o` and `irq_id_o` are all zero.
- R2: With sense code 00 (low level), `pend_o` is high exactly while the synchronised pad is low, two clock edges after the pad changes. Neither acknowledge nor clear affects it.
- R3: With sense code 01 (any change), both a rising and a falling pad transition set the pending flag.
- R4: With sense code 10 (falling edge), a high-to-low transition sets the flag and a low-to-high transition does not.
- R5: With sense code 11 (rising edge), a low-to-high transition sets the flag and a high-to-low transition does not.
- R6: In codes 01, 10 and 11 the pending flag stays set after the pad returns to its earlier level. A one-cycle pulse on that channel's `ack_i` bit clears it, and so does a one-cycle pulse on its `clr_i` bit.
- R7: An edge sets `pend_o` on the third rising clock edge after the pad changes and not before. A pad pulse held for one clock period is still detected.
- R8: When `pin_dir_i[n]` is 1, channel n senses `pin_out_i[n]` and ignores `pin_i[n]`. When `pin_dir_i[n]` is 0, `pin_out_i[n]` has no effect.
- R9: `irq_o` is 1 exactly when `gie_i` is 1 and at least one channel has both `pend_o` and `mask_i` set.
- R10: `irq_id_o` gives the lowest-indexed channel that is pending and enabled, so channel 0 has priority. It is 0 when no channel qualifies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_CH | Raw pad input values |
| pin_dir_i | input | NUM_CH | Pad direction, 1 = driven as output |
| pin_out_i | input | NUM_CH | Value driven onto the pad when it is an output |
| sense_i | input | 2*NUM_CH | Sense code per channel: bits [2n+1:2n] belong to channel n |
| mask_i | input | NUM_CH | Per-channel interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | NUM_CH | Per-channel acknowledge from the CPU |
| clr_i | input | NUM_CH | Per-channel write-one-to-clear strobe |
| pend_o | output | NUM_CH | Per-channel pending flag, or the live low level in mode 00 |
| irq_o | output | 1 | Combined interrupt request |
| irq_id_o | output | max(1,clog2(NUM_CH)) | Index of the channel that wins |

## Verification
The bench sweeps every sense code on every channel with both transition directions. It samples one cycle before and on the cycle where the flag is due. A design with a missing synchroniser stage, or with a latched level mode, fails on the early or the late sample. It also checks a one-cycle pulse, acknowledge pulses applied in level mode (these must change nothing), and a pad that is toggled only through its output driver with the raw input held high. A final sweep covers every mask and global-enable combination with one or both channels pending. A design with the priority reversed, or one that ignores the global enable, gives the wrong `irq_o` or `irq_id_o` there.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {N{RST_VAL}};
    else         ff_q <= {ff_q[N-2:0], d_i};
  end

  assign q_o = ff_q[N-1];
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   lvl_i,
  input  sense_e mode_i,
  input  logic   clr_i,
  output logic   pend_o
);
  logic prev_q, flag_q, flag_d;
  logic rise, fall, hit;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (mode_i)
      SENSE_ANY:  hit = rise | fall;
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      default:    hit = 1'b0;
    endcase
  end

  // a new event wins over a clear in the same cycle
  always_comb begin
    if (mode_i == SENSE_LOW) flag_d = 1'b0;
    else if (hit)            flag_d = 1'b1;
    else if (clr_i)          flag_d = 1'b0;
    else                     flag_d = flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      flag_q <= flag_d;
    end
  end

  assign pend_o = (mode_i == SENSE_LOW) ? ~lvl_i : flag_q;

  // R3
  any_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_ANY && lvl_i != prev_q) |=> flag_q);
  // R4
  fall_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_FALL && !lvl_i && prev_q) |=> flag_q);
  // R5
  rise_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_RISE && lvl_i && !prev_q) |=> flag_q);
  // R6
  clr_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != SENSE_LOW && clr_i && !hit) |=> !flag_q);
  // R2
  level_no_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SENSE_LOW) |=> !flag_q);
endmodule

// File: rtl/ext_irq_arb.sv
module ext_irq_arb #(
  parameter int N   = 2,
  parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   req_i,
  output logic           valid_o,
  output logic [IDW-1:0] id_o
);
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        id_o    = IDW'(i);
      end
    end
  end

  // R10
  winner_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> req_i[id_o]);
  // R10
  ch0_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[0] |-> (valid_o && id_o == '0));
  // R10
  idle_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (id_o == '0));
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int IDW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_CH-1:0]     pin_i,
  input  logic [NUM_CH-1:0]     pin_dir_i,
  input  logic [NUM_CH-1:0]     pin_out_i,
  input  logic [2*NUM_CH-1:0]   sense_i,
  input  logic [NUM_CH-1:0]     mask_i,
  input  logic                  gie_i,
  input  logic [NUM_CH-1:0]     ack_i,
  input  logic [NUM_CH-1:0]     clr_i,
  output logic [NUM_CH-1:0]     pend_o,
  output logic                  irq_o,
  output logic [IDW-1:0]        irq_id_o
);
  logic [NUM_CH-1:0] pad, lvl, req;

  // output driver value feeds the sense path: software interrupt
  assign pad = (pin_dir_i & pin_out_i) | (~pin_dir_i & pin_i);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ext_irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pad[g]),
      .q_o   (lvl[g])
    );

    ext_irq_detect u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (lvl[g]),
      .mode_i(sense_e'(sense_i[2*g +: 2])),
      .clr_i (ack_i[g] | clr_i[g]),
      .pend_o(pend_o[g])
    );
  end

  assign req = pend_o & mask_i & {NUM_CH{gie_i}};

  ext_irq_arb #(.N(NUM_CH), .IDW(IDW)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .valid_o(irq_o),
    .id_o   (irq_id_o)
  );

  // R9
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gie_i);
  // R9
  irq_needs_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|(pend_o & mask_i)));
endmodule

// File: tb/tb_ext_irq_sense.sv
module tb_ext_irq_sense;
  localparam int NCH = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NCH-1:0] pin_i = '1, pin_dir_i = '0, pin_out_i = '1;
  logic [2*NCH-1:0] sense_i = '0;
  logic [NCH-1:0] mask_i = '0, ack_i = '0, clr_i = '0;
  logic gie_i = 1'b0;
  logic [NCH-1:0] pend_o;
  logic irq_o;
  logic [0:0] irq_id_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_sense #(.NUM_CH(NCH), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin_i), .pin_dir_i(pin_dir_i),
    .pin_out_i(pin_out_i), .sense_i(sense_i), .mask_i(mask_i), .gie_i(gie_i),
    .ack_i(ack_i), .clr_i(clr_i), .pend_o(pend_o), .irq_o(irq_o),
    .irq_id_o(irq_id_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_clr(input logic [NCH-1:0] m);
    clr_i = m; step(1); clr_i = '0;
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(2);
    // R1 reset state
    chk("R1 pend", int'(pend_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 id", int'(irq_id_o), 0);

    // R2 R3 R4 R5 R7: every mode, channel and direction
    for (int c = 0; c < NCH; c++) begin
      for (int m = 0; m < 4; m++) begin
        for (int r = 0; r < 2; r++) begin
          int early, late;
          sense_i = '0;
          sense_i[2*c +: 2] = 2'(m);
          pin_i[c] = (r == 1) ? 1'b0 : 1'b1;
          step(4);
          pulse_clr('1);
          step(1);
          pin_i[c] = (r == 1) ? 1'b1 : 1'b0;
          step(2);
          early = (m == 0) ? (1 - r) : 0;
          chk($sformatf("R7 early ch%0d mode%0d rise%0d", c, m, r), int'(pend_o[c]), early);
          step(1);
          case (m)
            0: late = 1 - r;
            1: late = 1;
            2: late = 1 - r;
            default: late = r;
          endcase
          chk($sformatf("R2/R3/R4/R5 ch%0d mode%0d rise%0d", c, m, r), int'(pend_o[c]), late);
          chk($sformatf("R1 other ch quiet ch%0d mode%0d", c, m), int'(pend_o[1-c]), 0);
          pin_i = '1; sense_i = '0;
          step(4);
          pulse_clr('1);
        end
      end
    end

    // R7 one-cycle pulse in falling mode
    sense_i = 4'b0010;
    step(2);
    pin_i[0] = 1'b0; step(1); pin_i[0] = 1'b1;
    step(3);
    chk("R7 short pulse", int'(pend_o[0]), 1);
    // R6 sticky, then ack clears
    step(5);
    chk("R6 sticky", int'(pend_o[0]), 1);
    ack_i = 2'b01; step(1); ack_i = '0;
    chk("R6 ack clear", int'(pend_o[0]), 0);
    // R6 clear strobe on ch1 (rising mode)
    sense_i = 4'b1100;
    pin_i[1] = 1'b0; step(4);
    pulse_clr(2'b10); step(1);
    pin_i[1] = 1'b1; step(3);
    chk("R6 ch1 set", int'(pend_o[1]), 1);
    pulse_clr(2'b10);
    chk("R6 clr clear", int'(pend_o[1]), 0);

    // R2 ack has no effect in level mode
    sense_i = '0;
    pin_i[0] = 1'b0; step(2);
    ack_i = 2'b01; clr_i = 2'b01; step(1); ack_i = '0; clr_i = '0;
    chk("R2 ack ignored", int'(pend_o[0]), 1);
    pin_i[0] = 1'b1; step(2);
    chk("R2 released", int'(pend_o[0]), 0);

    // R8 software interrupt through output driver
    sense_i = 4'b0010;
    step(2);
    pin_dir_i[0] = 1'b1; pin_out_i[0] = 1'b1; step(3);
    pulse_clr('1);
    pin_out_i[0] = 1'b0; step(3);
    chk("R8 driven falling", int'(pend_o[0]), 1);
    pin_out_i[0] = 1'b1; step(3);
    pulse_clr('1);
    pin_dir_i[0] = 1'b0; step(3);
    pulse_clr('1);
    pin_out_i[0] = 1'b0; step(4);
    chk("R8 out ignored as input", int'(pend_o[0]), 0);
    pin_out_i = '1;

    // R9 R10: mask and enable sweep
    sense_i = 4'b0101;
    for (int both = 0; both < 2; both++) begin
      pulse_clr('1);
      if (both == 1) pin_i = 2'b00; else pin_i = 2'b01;
      step(3);
      for (int g = 0; g < 2; g++) begin
        for (int mk = 0; mk < 4; mk++) begin
          int p0, e_irq, e_id;
          gie_i = g[0]; mask_i = 2'(mk);
          step(1);
          p0 = both;
          e_irq = (g == 1) && (((mk & 1) != 0 && p0 == 1) || (mk & 2) != 0) ? 1 : 0;
          e_id = (e_irq == 1 && !((mk & 1) != 0 && p0 == 1)) ? 1 : 0;
          chk($sformatf("R9 irq both%0d gie%0d mask%0d", both, g, mk), int'(irq_o), e_irq);
          chk($sformatf("R10 id both%0d gie%0d mask%0d", both, g, mk), int'(irq_id_o), e_id);
        end
      end
      pin_i = '1; step(3);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule